// File: doc/BRIEF.md
# Buffered Program Load Sequencer

This block sits behind the command decoder of a parallel NOR flash controller. It takes the decoded write cycles of a buffered program sequence and collects them into a word buffer. Once the sequence is confirmed, it hands that buffer to the program engine. A sequence has four parts: a start cycle, a count cycle carrying N, then N+1 data cycles, then a confirm cycle. The start cycle names the target block. The count cycle asks for N+1 words. Each data cycle places one word at the offset given by its low address bits. The confirm cycle repeats the block address.

The whole burst must stay inside one aligned page of `WORDS` words. The block address is compared on the count cycle, on every data cycle and on the confirm cycle. Any violation does not truncate the burst. Instead the block moves to an abort state and reports it on a status flag. It leaves that state only when it sees a reset command. Buffer words that were not loaded keep the all-ones value, so the program engine leaves those cells untouched. The address of the last data cycle is held for later status polling.

Top module: `buf_prog_loader`

## Requirements
- R1: After reset, `busy`, `abort_flag` and `prog_req` are 0, `word_count` is 0, and every buffer word reads 0xFFFF.
- R2: In idle, a write whose data is 0x0025 starts a sequence. It captures the block field (address bits 23..16), sets every buffer word to 0xFFFF and raises `busy` one cycle later.
- R3: The write after the start is the count cycle. Its data is N. If N is 31 or less, `word_count` becomes N+1. If N is above 31, the block aborts.
- R4: Each data cycle writes its data into the buffer word selected by address bits 4..0. Words not written in the sequence stay 0xFFFF.
- R5: Every data cycle must carry the same address bits 23..5 as the first data cycle of the sequence. A different page aborts the sequence.
- R6: A count, data or confirm cycle whose address bits 23..16 differ from the block captured at the start aborts the sequence.
- R7: A confirm cycle is a write with data 0x0029 and a matching block, arriving after exactly N+1 data cycles. It raises `prog_req` for exactly one cycle and drops `busy`. `start_addr` then holds the page base, which is the page bits with bits 4..0 zero.
- R8: After N+1 data cycles, any write that is not a valid confirm aborts the sequence. This includes an extra data word.
- R9: An abort drops `busy` and sets `abort_flag` one cycle after the offending write. The flag then holds through any other write, including a new start. Only a write with data 0x00F0 clears it, and that returns the block to idle.
- R10: `last_addr` holds the full address of the most recent accepted data cycle.
- R11: In idle, writes whose data is not the start code leave `busy` and `abort_flag` at 0.
- R12: After a confirm, the buffer, `start_addr` and `word_count` hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One decoded bus write cycle this clock |
| wr_addr | input | 24 | Word address of the write cycle |
| wr_data | input | 16 | Data of the write cycle |
| buf_words | output | 512 | Buffer contents, word i at bits [16*i+15:16*i] |
| start_addr | output | 24 | Page base address of the loaded burst |
| word_count | output | 6 | Number of words requested (N+1) |
| last_addr | output | 24 | Address of the last accepted data cycle |
| busy | output | 1 | A load sequence is being collected |
| prog_req | output | 1 | One-cycle request to the program engine |
| abort_flag | output | 1 | Sequence aborted; waits for a reset command |

## Verification
Every output is a register. The results of a write sampled at clock edge k are therefore visible right after edge k. `prog_req` is high only between edges k and k+1.

The driver presents each write at a falling edge. It also pushes the expected `busy`, `abort_flag` and `prog_req` values, tagged with the number of the rising edge that will sample the write. The monitor compares at the falling edge once that rising edge has passed. Buffer, count and address checks are made at the same falling edge, after the write has been taken. Each write is followed by one idle cycle, so a one-cycle `prog_req` pulse is seen exactly once and then confirmed low.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COUNT   = 3'd1,
        ST_LOAD    = 3'd2,
        ST_CONFIRM = 3'd3,
        ST_ABORT   = 3'd4
    } lbuf_state_e;

    localparam logic [7:0] CODE_LOAD    = 8'h25;
    localparam logic [7:0] CODE_CONFIRM = 8'h29;
    localparam logic [7:0] CODE_RESET   = 8'hF0;

endpackage

// File: rtl/lbuf_addr_check.sv
module lbuf_addr_check #(
    parameter int ADDR_W  = 24,
    parameter int BLK_LSB = 16,
    parameter int IDX_W   = 5,
    localparam int BLK_W  = ADDR_W - BLK_LSB,
    localparam int PG_W   = ADDR_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BLK_W-1:0]  blk_ref,
    input  logic [PG_W-1:0]   page_ref,
    output logic [BLK_W-1:0]  blk_of,
    output logic [PG_W-1:0]   page_of,
    output logic [IDX_W-1:0]  idx_of,
    output logic              blk_ok,
    output logic              page_ok
);
    // Split the address into its block, page and word-offset fields.
    always_comb begin
        blk_of  = addr[ADDR_W-1:BLK_LSB];
        page_of = addr[ADDR_W-1:IDX_W];
        idx_of  = addr[IDX_W-1:0];
        blk_ok  = (blk_of == blk_ref);
        page_ok = (page_of == page_ref);
    end
endmodule

// File: rtl/lbuf_store.sv
module lbuf_store #(
    parameter int WORDS  = 32,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fill_ones,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [DATA_W-1:0]       wdata,
    output logic [WORDS*DATA_W-1:0] words_flat
);
    logic [DATA_W-1:0] mem_d [WORDS];
    logic [DATA_W-1:0] mem_q [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_comb begin
            mem_d[i] = mem_q[i];
            if (fill_ones) begin
                mem_d[i] = '1;
            end else if (we && (idx == IDX_W'(i))) begin
                mem_d[i] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[i] <= '1;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end

        assign words_flat[i*DATA_W +: DATA_W] = mem_q[i];
    end
endmodule

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl
    import lbuf_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 16,
    parameter int WORDS   = 32,
    parameter int BLK_LSB = 16,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int CNT_W  = IDX_W + 1,
    localparam int BLK_W  = ADDR_W - BLK_LSB,
    localparam int PG_W   = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BLK_W-1:0]  wr_blk,
    input  logic [PG_W-1:0]   wr_page,
    input  logic              blk_ok,
    input  logic              page_ok,
    output logic [BLK_W-1:0]  blk_ref,
    output logic [PG_W-1:0]   page_ref,
    output logic              fill_ones,
    output logic              store_we,
    output logic [CNT_W-1:0]  word_count,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] last_addr,
    output logic              busy,
    output logic              prog_req,
    output logic              abort_flag
);
    typedef struct packed {
        lbuf_state_e       st;
        logic [BLK_W-1:0]  blk;
        logic [PG_W-1:0]   page;
        logic              first;
        logic [IDX_W-1:0]  n;
        logic [CNT_W-1:0]  loaded;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] last;
        logic              prog;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic             is_load, is_confirm, is_reset, n_too_big;
    logic [CNT_W-1:0] loaded_nxt, target;

    always_comb begin
        is_load    = (wr_data == DATA_W'(CODE_LOAD));
        is_confirm = (wr_data == DATA_W'(CODE_CONFIRM));
        is_reset   = (wr_data == DATA_W'(CODE_RESET));
        n_too_big  = (wr_data > DATA_W'(WORDS - 1));
        loaded_nxt = r_q.loaded + CNT_W'(1);
        target     = {1'b0, r_q.n} + CNT_W'(1);

        r_d       = r_q;
        r_d.prog  = 1'b0;
        fill_ones = 1'b0;
        store_we  = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (wr_en && is_load) begin
                    r_d.st     = ST_COUNT;
                    r_d.blk    = wr_blk;
                    r_d.first  = 1'b1;
                    r_d.loaded = '0;
                    r_d.cnt    = '0;
                    r_d.n      = '0;
                    fill_ones  = 1'b1;
                end
            end
            ST_COUNT: begin
                if (wr_en) begin
                    if (!blk_ok || n_too_big) begin
                        r_d.st = ST_ABORT;
                    end else begin
                        r_d.n   = wr_data[IDX_W-1:0];
                        r_d.cnt = {1'b0, wr_data[IDX_W-1:0]} + CNT_W'(1);
                        r_d.st  = ST_LOAD;
                    end
                end
            end
            ST_LOAD: begin
                if (wr_en) begin
                    if (!blk_ok || (!r_q.first && !page_ok)) begin
                        r_d.st = ST_ABORT;
                    end else begin
                        store_we   = 1'b1;
                        r_d.first  = 1'b0;
                        r_d.page   = wr_page;
                        r_d.last   = wr_addr;
                        r_d.loaded = loaded_nxt;
                        if (loaded_nxt == target) begin
                            r_d.st = ST_CONFIRM;
                        end
                    end
                end
            end
            ST_CONFIRM: begin
                if (wr_en) begin
                    if (is_confirm && blk_ok) begin
                        r_d.prog = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.st = ST_ABORT;
                    end
                end
            end
            ST_ABORT: begin
                if (wr_en && is_reset) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, blk: '0, page: '0, first: 1'b1, n: '0,
                     loaded: '0, cnt: '0, last: '0, prog: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign blk_ref    = r_q.blk;
    assign page_ref   = r_q.page;
    assign word_count = r_q.cnt;
    assign start_addr = {r_q.page, {IDX_W{1'b0}}};
    assign last_addr  = r_q.last;
    assign busy       = (r_q.st == ST_COUNT) || (r_q.st == ST_LOAD) || (r_q.st == ST_CONFIRM);
    assign abort_flag = (r_q.st == ST_ABORT);
    assign prog_req   = r_q.prog;
endmodule

// File: rtl/buf_prog_loader.sv
module buf_prog_loader #(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 16,
    parameter int WORDS   = 32,
    parameter int BLK_LSB = 16,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int CNT_W  = IDX_W + 1,
    localparam int BLK_W  = ADDR_W - BLK_LSB,
    localparam int PG_W   = ADDR_W - IDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [WORDS*DATA_W-1:0] buf_words,
    output logic [ADDR_W-1:0]       start_addr,
    output logic [CNT_W-1:0]        word_count,
    output logic [ADDR_W-1:0]       last_addr,
    output logic                    busy,
    output logic                    prog_req,
    output logic                    abort_flag
);
    logic [BLK_W-1:0] blk_ref, wr_blk;
    logic [PG_W-1:0]  page_ref, wr_page;
    logic [IDX_W-1:0] wr_idx;
    logic             blk_ok, page_ok, fill_ones, store_we;

    lbuf_addr_check #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .IDX_W(IDX_W)) u_chk_addr (
        .addr(wr_addr), .blk_ref(blk_ref), .page_ref(page_ref),
        .blk_of(wr_blk), .page_of(wr_page), .idx_of(wr_idx),
        .blk_ok(blk_ok), .page_ok(page_ok)
    );

    lbuf_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .BLK_LSB(BLK_LSB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_blk(wr_blk), .wr_page(wr_page), .blk_ok(blk_ok), .page_ok(page_ok),
        .blk_ref(blk_ref), .page_ref(page_ref), .fill_ones(fill_ones), .store_we(store_we),
        .word_count(word_count), .start_addr(start_addr), .last_addr(last_addr),
        .busy(busy), .prog_req(prog_req), .abort_flag(abort_flag)
    );

    lbuf_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .fill_ones(fill_ones), .we(store_we),
        .idx(wr_idx), .wdata(wr_data), .words_flat(buf_words)
    );
endmodule

// File: rtl/lbuf_checker.sv
module lbuf_checker #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 32,
    localparam int CNT_W = $clog2(WORDS) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              busy,
    input logic              prog_req,
    input logic              abort_flag,
    input logic [CNT_W-1:0]  word_count
);
    // R7
    prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);
    // R7
    prog_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> (!busy && !abort_flag));
    // R9
    abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_flag && busy));
    // R9
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_flag && !(wr_en && wr_data == DATA_W'(8'hF0))) |=> abort_flag);
    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_count <= CNT_W'(WORDS));
    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && wr_data == DATA_W'(8'h25)));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !abort_flag && !(wr_en && wr_data == DATA_W'(8'h25))) |=> !busy);
endmodule

bind buf_prog_loader lbuf_checker #(.DATA_W(DATA_W), .WORDS(WORDS)) u_lbuf_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
    .prog_req(prog_req), .abort_flag(abort_flag), .word_count(word_count)
);

// File: tb/tb_buf_prog_loader.sv
`timescale 1ns/1ps
module tb_buf_prog_loader;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [23:0]  wr_addr = '0;
    logic [15:0]  wr_data = '0;
    logic [511:0] buf_words;
    logic [23:0]  start_addr, last_addr;
    logic [5:0]   word_count;
    logic         busy, prog_req, abort_flag;

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;

    typedef struct {
        int    due;
        logic  busy;
        logic  abort;
        logic  prog;
        string req;
    } exp_t;
    exp_t exp_q[$];

    buf_prog_loader dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .buf_words(buf_words), .start_addr(start_addr), .word_count(word_count),
        .last_addr(last_addr), .busy(busy), .prog_req(prog_req), .abort_flag(abort_flag)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare status flags once the sampling edge has passed
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            vectors++;
            if ({busy, abort_flag, prog_req} !== {e.busy, e.abort, e.prog}) begin
                misses++;
                $display("FAIL %s: busy/abort/prog = %b%b%b expected %b%b%b",
                         e.req, busy, abort_flag, prog_req, e.busy, e.abort, e.prog);
            end
        end
    end

    task automatic wr(input logic [23:0] a, input logic [15:0] d,
                      input logic eb, input logic ea, input logic ep, input string req);
        exp_t e;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        e.due = cyc + 1; e.busy = eb; e.abort = ea; e.prog = ep; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string req);
        vectors++;
        if (act !== expv) begin
            misses++;
            $display("FAIL %s: got %h expected %h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] word_at(input int i);
        return buf_words[i*16 +: 16];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: run did not complete, got timeout expected end");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        chk({29'd0, busy, abort_flag, prog_req}, 32'd0, "R1 flags");
        chk({26'd0, word_count}, 32'd0, "R1 count");
        chk({16'd0, word_at(0)}, 32'hFFFF, "R1 word0");
        chk({16'd0, word_at(31)}, 32'hFFFF, "R1 word31");

        // R11 idle writes ignored
        wr(24'h123440, 16'h0029, 0, 0, 0, "R11 idle confirm code");
        wr(24'h123440, 16'h00F0, 0, 0, 0, "R11 idle reset code");

        // Normal four-word burst
        wr(24'h123440, 16'h0025, 1, 0, 0, "R2 start");
        wr(24'h123440, 16'h0003, 1, 0, 0, "R3 count");
        chk({26'd0, word_count}, 32'd4, "R3 word_count");
        wr(24'h123442, 16'hA0A0, 1, 0, 0, "R4 data");
        wr(24'h123440, 16'hB1B1, 1, 0, 0, "R4 data");
        wr(24'h123447, 16'hC2C2, 1, 0, 0, "R4 data");
        wr(24'h12345F, 16'hD3D3, 1, 0, 0, "R4 data");
        chk({8'd0, last_addr}, 32'h12345F, "R10 last_addr");
        wr(24'h120000, 16'h0029, 0, 0, 1, "R7 confirm");
        wr(24'h000000, 16'h0000, 0, 0, 0, "R7 pulse ends / R11 idle");
        chk({16'd0, word_at(2)},  32'hA0A0, "R4 word2");
        chk({16'd0, word_at(0)},  32'hB1B1, "R4 word0");
        chk({16'd0, word_at(7)},  32'hC2C2, "R4 word7");
        chk({16'd0, word_at(31)}, 32'hD3D3, "R4 word31");
        chk({16'd0, word_at(5)},  32'hFFFF, "R4 unloaded word5");
        chk({8'd0, start_addr}, 32'h123440, "R7 start_addr");
        chk({26'd0, word_count}, 32'd4, "R12 count held");

        // Count too large; start refused while aborted; reset clears
        wr(24'h600000, 16'h0025, 1, 0, 0, "R2 start");
        chk({16'd0, word_at(7)}, 32'hFFFF, "R2 buffer refilled");
        wr(24'h600000, 16'h0020, 0, 1, 0, "R3 count over 31");
        wr(24'h600000, 16'h0025, 0, 1, 0, "R9 start while aborted");
        wr(24'h600000, 16'h00F0, 0, 0, 0, "R9 reset clears");

        // Page violation
        wr(24'h200000, 16'h0025, 1, 0, 0, "R2 start");
        wr(24'h200000, 16'h0001, 1, 0, 0, "R3 count");
        wr(24'h200010, 16'h1111, 1, 0, 0, "R5 first data");
        wr(24'h200020, 16'h2222, 0, 1, 0, "R5 page change");
        wr(24'h200000, 16'h00F0, 0, 0, 0, "R9 reset");

        // Block mismatch on count cycle
        wr(24'h300000, 16'h0025, 1, 0, 0, "R2 start");
        wr(24'h310000, 16'h0000, 0, 1, 0, "R6 count block");
        wr(24'h300000, 16'h00F0, 0, 0, 0, "R9 reset");

        // Block mismatch on confirm cycle
        wr(24'h400000, 16'h0025, 1, 0, 0, "R2 start");
        wr(24'h400000, 16'h0000, 1, 0, 0, "R3 count");
        wr(24'h400003, 16'h3333, 1, 0, 0, "R4 data");
        wr(24'h410000, 16'h0029, 0, 1, 0, "R6 confirm block");
        wr(24'h400000, 16'h00F0, 0, 0, 0, "R9 reset");

        // Extra data word instead of confirm
        wr(24'h700000, 16'h0025, 1, 0, 0, "R2 start");
        wr(24'h700000, 16'h0000, 1, 0, 0, "R3 count");
        wr(24'h700001, 16'h4444, 1, 0, 0, "R4 data");
        wr(24'h700002, 16'h5555, 0, 1, 0, "R8 extra data");
        wr(24'h700000, 16'h00F0, 0, 0, 0, "R9 reset");

        // Full 32-word burst
        wr(24'h5003E0, 16'h0025, 1, 0, 0, "R2 start");
        wr(24'h5003E0, 16'h001F, 1, 0, 0, "R3 count 31");
        chk({26'd0, word_count}, 32'd32, "R3 word_count max");
        for (int i = 0; i < 32; i++) begin
            wr(24'h5003E0 + 24'(i), 16'(i * 3 + 1), 1, 0, 0, "R4 full data");
        end
        wr(24'h500000, 16'h0029, 0, 0, 1, "R7 confirm full");
        wr(24'h000000, 16'h1234, 0, 0, 0, "R12 idle after confirm");
        for (int i = 0; i < 32; i++) begin
            chk({16'd0, word_at(i)}, {16'd0, 16'(i * 3 + 1)}, "R4 full word");
        end
        chk({8'd0, start_addr}, 32'h5003E0, "R7 start_addr full");
        chk({8'd0, last_addr}, 32'h5003FF, "R10 last_addr full");
        chk({26'd0, word_count}, 32'd32, "R12 count held");

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule